// File: doc/BRIEF.md
# Card Host Event Status and Interrupt Mask Unit

This unit collects the event and level flags of a memory-card host controller into one 22-bit status word and drives two interrupt lines, each with its own 32-bit enable mask. The command and data engines pulse sticky event bits into the low part of the word. They also present FIFO and activity levels, which fill the upper part. Software reads the status word and acknowledges events through a write-one-to-clear register.

The unit also owns a transfer-hold flag that paces the data engine. Every read of the FIFO data window that returns a word raises the flag, and the data engine must not move more data while it is high. A later read of the status word or of the word-count register returns its value and then drops the flag, so the engine may go on. Register access uses a single-cycle valid/address bus. Read data is combinational from the current state, and writes and read side effects take effect at the clock edge that accepts the access.

Address map (word addresses on `reg_addr`): 0 status (read), 1 clear (write), 2 mask A, 3 mask B, 4 word count (read), 8 to 15 FIFO data window (decoded when the top address bit is 1).

Top module: `sdio_evt_status`

## Requirements
- R1: After reset, the status word, both masks, both interrupt lines and the hold flag are all zero.
- R2: A 1 on `evt_set[i]` for one cycle sets status bit i at that clock edge. The bit stays set until it is cleared.
- R3: A write to the clear address clears exactly those sticky status bits whose positions hold a 1 in `reg_wdata[10:0]`. Bits 31:11 of the written value have no effect.
- R4: Status bit 9 is reserved and always reads 0, even when `evt_set[9]` is pulsed.
- R5: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: Status bits 21:11 show the value of `lvl_flags[10:0]` registered one clock earlier. A clear write never changes them.
- R7: `irq[0]` is high exactly when the status word ANDed with mask A is nonzero, and `irq[1]` does the same with mask B. Both masks read back as written.
- R8: A read of the FIFO window while `fifo_has_data` is 1 sets `xfer_hold` at that edge. A read while it is 0 leaves `xfer_hold` unchanged.
- R9: A read of the status word or of the word count returns the value from before the access, then clears `xfer_hold` at that edge.
- R10: Status bits 31:22 read 0. Reads of the clear address and of the FIFO window return 0, and the word count reads as `word_count` zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access in this cycle |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current access |
| evt_set | input | 11 | One-cycle event pulses for sticky bits 10:0 |
| lvl_flags | input | 11 | Level flags for status bits 21:11 |
| fifo_has_data | input | 1 | FIFO holds at least one word |
| word_count | input | WC_W | Remaining word count from the data engine |
| irq | output | 2 | Masked interrupt lines A and B |
| xfer_hold | output | 1 | Data engine must pause while high |

## Verification
If a sticky bit were wrongly cleared or set, the next status read would return the wrong value, and an interrupt line with that bit enabled would change level in the cycle after the edge. If the hold flag were wrong, `xfer_hold` would show it one edge after the FIFO read or the poll that should have changed it, so the data engine would stall or run on. If priority went the wrong way, a set that collides with a clear would be lost. That would show only as a missing bit on the next read.

// File: rtl/sdio_evt_status.sv
module sdio_evt_status #(
  parameter int ADDR_W = 4,
  parameter int WC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [10:0]       evt_set,
  input  logic [10:0]       lvl_flags,
  input  logic              fifo_has_data,
  input  logic [WC_W-1:0]   word_count,
  output logic [1:0]        irq,
  output logic              xfer_hold
);
  localparam int EVT_W  = 11;
  localparam int STAT_W = 22;
  localparam int LVL_W  = STAT_W - EVT_W;
  localparam logic [EVT_W-1:0] EVT_KEEP = 11'h5FF;
  localparam logic [ADDR_W-1:0] A_STAT = 0;
  localparam logic [ADDR_W-1:0] A_CLR  = 1;
  localparam logic [ADDR_W-1:0] A_MSKA = 2;
  localparam logic [ADDR_W-1:0] A_MSKB = 3;
  localparam logic [ADDR_W-1:0] A_WCNT = 4;

  logic [EVT_W-1:0] sticky;
  logic [LVL_W-1:0] level;
  logic [31:0]      mask_a, mask_b;
  logic             hold;

  wire [STAT_W-1:0] status   = {level, sticky};
  wire              rd       = reg_valid & ~reg_write;
  wire              wr       = reg_valid & reg_write;
  wire              fifo_hit = reg_addr[ADDR_W-1];
  wire              clr_hit  = wr && reg_addr == A_CLR;
  wire [EVT_W-1:0]  clr_bits = clr_hit ? reg_wdata[EVT_W-1:0] : '0;
  wire              pop_ok   = rd & fifo_hit & fifo_has_data;
  wire              poll     = rd && !fifo_hit && (reg_addr == A_STAT || reg_addr == A_WCNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky <= '0;
      level  <= '0;
      mask_a <= '0;
      mask_b <= '0;
      hold   <= 1'b0;
    end else begin
      sticky <= ((sticky & ~clr_bits) | evt_set) & EVT_KEEP;
      level  <= lvl_flags;
      if (wr && !fifo_hit && reg_addr == A_MSKA) mask_a <= reg_wdata;
      if (wr && !fifo_hit && reg_addr == A_MSKB) mask_b <= reg_wdata;
      if (pop_ok)    hold <= 1'b1;
      else if (poll) hold <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (rd && !fifo_hit) begin
      case (reg_addr)
        A_STAT:  reg_rdata = {{(32-STAT_W){1'b0}}, status};
        A_MSKA:  reg_rdata = mask_a;
        A_MSKB:  reg_rdata = mask_b;
        A_WCNT:  reg_rdata = {{(32-WC_W){1'b0}}, word_count};
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq[0]    = |(status & mask_a[STAT_W-1:0]);
  assign irq[1]    = |(status & mask_b[STAT_W-1:0]);
  assign xfer_hold = hold;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_set & EVT_KEEP)) |=> ((sticky & $past(evt_set & EVT_KEEP)) == $past(evt_set & EVT_KEEP))); // R5
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> ((sticky & $past(sticky)) == $past(sticky))); // R2
  AST_CLR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && evt_set == '0) |=> (sticky == ($past(sticky) & ~$past(reg_wdata[EVT_W-1:0])))); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !sticky[9]); // R4
  AST_LVL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> level == $past(lvl_flags)); // R6
  AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> xfer_hold); // R8
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    poll |=> !xfer_hold); // R9
endmodule

// File: tb/sdio_evt_status_tb.sv
module sdio_evt_status_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_valid = 0, reg_write = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [10:0] evt_set = 0, lvl_flags = 0;
  logic        fifo_has_data = 0;
  logic [15:0] word_count = 0;
  logic [1:0]  irq;
  logic        xfer_hold;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  sdio_evt_status u_dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_set(evt_set), .lvl_flags(lvl_flags), .fifo_has_data(fifo_has_data),
    .word_count(word_count), .irq(irq), .xfer_hold(xfer_hold));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #5;
    if (reg_valid && !reg_write && exp_q.size() > 0)
      check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
  end

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_valid = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic pulse(logic [10:0] e);
    evt_set = e;
    @(negedge clk);
    evt_set = 0;
  endtask

  task automatic sample_out(string tag, logic [1:0] exp_irq, logic exp_hold);
    #5;
    check({tag, " irq"}, {30'd0, irq}, {30'd0, exp_irq});
    check({tag, " hold"}, {31'd0, xfer_hold}, {31'd0, exp_hold});
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    sample_out("R1 reset", 2'b00, 1'b0);
    rd(0, 32'h0, "R1 status");
    rd(2, 32'h0, "R1 maskA");
    rd(3, 32'h0, "R1 maskB");
    // R2 sticky set
    pulse(11'h001);
    rd(0, 32'h1, "R2 set");
    rd(0, 32'h1, "R2 stays");
    // R4 reserved bit
    pulse(11'h200);
    rd(0, 32'h1, "R4 bit9");
    // R3 upper write bits do nothing
    wr(1, 32'hFFFFF800);
    rd(0, 32'h1, "R3 upper ignored");
    // R6 level bits and clear immunity
    lvl_flags = 11'h7FF;
    @(negedge clk);
    rd(0, 32'h3FF801, "R6 level");
    wr(1, 32'hFFFFFFFF);
    rd(0, 32'h3FF800, "R3 R6 clear all");
    lvl_flags = 0;
    @(negedge clk);
    rd(0, 32'h0, "R6 level drop");
    // R3 partial clear
    pulse(11'h5FF);
    rd(0, 32'h5FF, "R2 all events");
    wr(1, 32'h0F0);
    rd(0, 32'h50F, "R3 partial");
    // R5 set beats clear
    evt_set = 11'h001; reg_valid = 1; reg_write = 1; reg_addr = 1; reg_wdata = 32'h1;
    @(negedge clk);
    evt_set = 0; reg_valid = 0; reg_write = 0;
    rd(0, 32'h50F, "R5 set wins");
    // R7 masks and interrupts
    wr(2, 32'h100);
    sample_out("R7 maskA", 2'b01, 1'b0);
    rd(2, 32'h100, "R7 maskA rb");
    wr(3, 32'h20000);
    sample_out("R7 maskB idle", 2'b01, 1'b0);
    rd(3, 32'h20000, "R7 maskB rb");
    lvl_flags = 11'h040;
    @(negedge clk);
    sample_out("R7 level irq", 2'b11, 1'b0);
    wr(1, 32'h7FF);
    sample_out("R7 after clear", 2'b10, 1'b0);
    lvl_flags = 0;
    @(negedge clk);
    sample_out("R7 level gone", 2'b00, 1'b0);
    // R8 hold flag
    fifo_has_data = 0;
    rd(8, 32'h0, "R10 fifo empty");
    sample_out("R8 empty read", 2'b00, 1'b0);
    fifo_has_data = 1;
    rd(12, 32'h0, "R10 fifo read");
    sample_out("R8 hold set", 2'b00, 1'b1);
    // R9 release by word count, then by status
    word_count = 16'h0123;
    rd(4, 32'h123, "R9 wcount");
    sample_out("R9 wcount release", 2'b00, 1'b0);
    rd(9, 32'h0, "R10 fifo read2");
    sample_out("R8 hold again", 2'b00, 1'b1);
    rd(0, 32'h0, "R9 status");
    sample_out("R9 status release", 2'b00, 1'b0);
    rd(1, 32'h0, "R10 clear addr");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard drain", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end
endmodule